// File: doc/BRIEF.md
# Read-Return Tag Router

This block sits beside the arbiter of a shared memory controller and steers returning read data to the client that asked for it. Each time the arbiter hands a read to the controller, it also presents the requesting client's number and the burst length here. That pair goes into a small tag queue. Only the client number and the beat count are stored; the read data itself is never buffered.

Returning beats are driven unchanged onto one data bus that every client sees. A per-client valid vector picks out the owner of each beat. Exactly one valid bit rises, the one whose index matches the client number at the head of the queue. After the head entry's last beat, the entry is retired and the next one takes over.

The design relies on the controller returning reads in the order they were issued. A small state machine tracks the head entry. It has three states. S_IDLE means no tag is held. S_HEAD means a tag is at the head and none of its beats has arrived. S_MID means a burst is partly delivered. The transitions are:
- S_IDLE to S_HEAD when a read is accepted.
- S_HEAD to S_MID when a beat arrives that is not the last of its burst.
- S_HEAD or S_MID back to S_HEAD when the last beat arrives and another tag remains or is being accepted in that cycle.
- S_HEAD or S_MID back to S_IDLE when the last beat empties the queue.

A beat that arrives in S_IDLE has no owner. It is not routed, and it sets a sticky error flag.

Top module: `rtr_top`

## Requirements
- R1: A read presented with `iss_valid` high while `iss_ready` is high is accepted. Its `iss_client` and `iss_len` are stored as one tag. `iss_ready` is low exactly when DEPTH tags are held (default DEPTH is 4).
- R2: `bc_data` equals `ret_data` in the same cycle, whatever the state.
- R3: In a cycle where `ret_valid` is high and at least one tag is held, `bc_valid` has exactly one bit set, at bit index equal to the head tag's client number, in that same cycle. In every other cycle `bc_valid` is all zero.
- R4: `iss_len` holds the number of beats minus one, so a value of L gives L+1 beats. The head tag owns that many consecutive valid beats, and it is retired on the last of them.
- R5: Tags are served in the order they were accepted.
- R6: A read presented while `iss_ready` is low is dropped and never receives beats.
- R7: A valid beat that arrives while no tag is held asserts no `bc_valid` bit. From the next cycle on, `err_orphan` is high and stays high until reset.
- R8: While `rst_n` is low, and afterwards until a read is accepted, no tag is held. During reset `err_orphan` is low and `iss_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | A read is being issued to the memory controller |
| iss_client | input | ID_W (3) | Number of the client that issued the read |
| iss_len | input | LEN_W (4) | Burst length of the read, minus one |
| iss_ready | output | 1 | Tag queue has room; the arbiter issues only while high |
| ret_valid | input | 1 | A returning read beat is on `ret_data` |
| ret_data | input | DATA_W (32) | Returning read data from the controller |
| bc_data | output | DATA_W (32) | Read data broadcast to all clients |
| bc_valid | output | NUM_CLIENTS (5) | One valid strobe per client |
| err_orphan | output | 1 | Sticky flag: a beat arrived with no tag held |

## Verification
The assertions assume the following about the inputs:
- The controller returns exactly L+1 beats for each accepted read.
- Beats come back in issue order.
- No beat arrives before its read has been accepted.
- Every client number is below NUM_CLIENTS.

The stimulus table keeps to these rules. It issues only numbers 0 to 4, and it delivers one beat per expected beat of the head tag. The one exception is the deliberate unowned beat, which the block is specified to absorb through the error flag. Under these conditions the assertions hold:
- The state machine agrees with the queue's empty flag.
- The beat counter never passes the head length.
- A strobe never appears without a returning beat.
- The tag count never exceeds DEPTH.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HEAD = 2'd1,
        S_MID  = 2'd2
    } rtr_state_e;

endpackage

// File: rtl/rtr_tag_fifo.sv
module rtr_tag_fifo #(
    parameter int ID_W  = 3,
    parameter int LEN_W = 4,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ID_W-1:0]  push_id,
    input  logic [LEN_W-1:0] push_len,
    input  logic             pop,
    output logic [ID_W-1:0]  head_id,
    output logic [LEN_W-1:0] head_len,
    output logic             empty,
    output logic             full,
    output logic             single
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic [ID_W-1:0]  id_mem  [DEPTH];
    logic [LEN_W-1:0] len_mem [DEPTH];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_entry
            always_ff @(posedge clk) begin
                if (push && (wr_ptr == PTR_W'(gi))) begin
                    id_mem[gi]  <= push_id;
                    len_mem[gi] <= push_len;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_id  = id_mem[rd_ptr];
    assign head_len = len_mem[rd_ptr];
    assign empty    = (count == '0);
    assign full     = (count == FULL_CNT);
    assign single   = (count == CNT_W'(1));

    // R1: never more tags than storage
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R4: retiring a tag requires one to be held
    a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

endmodule

// File: rtl/rtr_beat_ctrl.sv
module rtr_beat_ctrl
    import rtr_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             push,
    input  logic             empty,
    input  logic             single,
    input  logic [LEN_W-1:0] head_len,
    output logic             route_en,
    output logic             pop,
    output logic             err_orphan
);

    rtr_state_e       state;
    rtr_state_e       state_nxt;
    logic [LEN_W-1:0] beat_cnt;
    logic             err_q;
    logic             last_beat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            beat_cnt <= '0;
            err_q    <= 1'b0;
        end else begin
            state <= state_nxt;
            if (last_beat) begin
                beat_cnt <= '0;
            end else if (route_en) begin
                beat_cnt <= beat_cnt + 1'b1;
            end
            if (beat && (state == S_IDLE)) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        route_en  = 1'b0;
        last_beat = 1'b0;
        state_nxt = state;
        unique case (state)
            S_IDLE: begin
                if (push) begin
                    state_nxt = S_HEAD;
                end
            end
            S_HEAD, S_MID: begin
                route_en  = beat;
                last_beat = beat && (beat_cnt == head_len);
                if (last_beat) begin
                    state_nxt = (single && !push) ? S_IDLE : S_HEAD;
                end else if (beat) begin
                    state_nxt = S_MID;
                end
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    assign pop        = last_beat;
    assign err_orphan = err_q;

    // R5: state machine view of the head agrees with the tag queue
    a_r5_idle_matches_queue: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) == empty);

    // R4: a fresh head has received no beats
    a_r4_head_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HEAD) |-> (beat_cnt == '0));

    // R4: the beat count stays within the head burst
    a_r4_cnt_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> (beat_cnt <= head_len));

    // R7: error flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_orphan |=> err_orphan);

endmodule

// File: rtl/rtr_valid_decode.sv
module rtr_valid_decode #(
    parameter int NUM_CLIENTS = 5,
    parameter int ID_W        = 3
) (
    input  logic                   en,
    input  logic [ID_W-1:0]        id,
    output logic [NUM_CLIENTS-1:0] vld
);

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CLIENTS; gc++) begin : g_client
            assign vld[gc] = en && (id == ID_W'(gc));
        end
    endgenerate

endmodule

// File: rtl/rtr_top.sv
module rtr_top #(
    parameter int NUM_CLIENTS = 5,
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 4,
    parameter int DEPTH       = 4,
    parameter int ID_W        = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   iss_valid,
    input  logic [ID_W-1:0]        iss_client,
    input  logic [LEN_W-1:0]       iss_len,
    output logic                   iss_ready,
    input  logic                   ret_valid,
    input  logic [DATA_W-1:0]      ret_data,
    output logic [DATA_W-1:0]      bc_data,
    output logic [NUM_CLIENTS-1:0] bc_valid,
    output logic                   err_orphan
);

    logic             push;
    logic             pop;
    logic             empty;
    logic             full;
    logic             single;
    logic             route_en;
    logic [ID_W-1:0]  head_id;
    logic [LEN_W-1:0] head_len;

    assign push      = iss_valid && !full;
    assign iss_ready = !full;
    assign bc_data   = ret_data;

    rtr_tag_fifo #(
        .ID_W  (ID_W),
        .LEN_W (LEN_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_id  (iss_client),
        .push_len (iss_len),
        .pop      (pop),
        .head_id  (head_id),
        .head_len (head_len),
        .empty    (empty),
        .full     (full),
        .single   (single)
    );

    rtr_beat_ctrl #(
        .LEN_W (LEN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat       (ret_valid),
        .push       (push),
        .empty      (empty),
        .single     (single),
        .head_len   (head_len),
        .route_en   (route_en),
        .pop        (pop),
        .err_orphan (err_orphan)
    );

    rtr_valid_decode #(
        .NUM_CLIENTS (NUM_CLIENTS),
        .ID_W        (ID_W)
    ) u_dec (
        .en  (route_en),
        .id  (head_id),
        .vld (bc_valid)
    );

    // R3: a strobe only accompanies a returning beat
    a_r3_valid_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (|bc_valid) |-> ret_valid);

    // R3: no strobe while the tag queue is empty
    a_r3_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (bc_valid == '0));

    // R3: at most one client strobed per beat
    a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bc_valid));

    // R7: an unowned beat raises the flag on the next cycle
    a_r7_orphan_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && empty) |=> err_orphan);

endmodule

// File: tb/rtr_top_tb.sv
`timescale 1ns/100ps
module rtr_top_tb;

    localparam int NC = 5;
    localparam int DW = 32;
    localparam int LW = 4;
    localparam int IW = 3;
    localparam int NV = 19;

    // row fields: iss_valid, client, len, ret_valid, exp bc_valid, exp ready, exp err
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 3'd2, 4'd1, 1'b0, 5'b00000, 1'b1, 1'b0},
        {1'b1, 3'd4, 4'd0, 1'b1, 5'b00100, 1'b1, 1'b0},
        {1'b0, 3'd0, 4'd0, 1'b1, 5'b00100, 1'b1, 1'b0},
        {1'b0, 3'd0, 4'd0, 1'b1, 5'b10000, 1'b1, 1'b0},
        {1'b1, 3'd0, 4'd2, 1'b0, 5'b00000, 1'b1, 1'b0},
        {1'b1, 3'd1, 4'd0, 1'b0, 5'b00000, 1'b1, 1'b0},
        {1'b1, 3'd3, 4'd0, 1'b0, 5'b00000, 1'b1, 1'b0},
        {1'b1, 3'd2, 4'd0, 1'b0, 5'b00000, 1'b1, 1'b0},
        {1'b1, 3'd4, 4'd0, 1'b1, 5'b00001, 1'b0, 1'b0},
        {1'b0, 3'd0, 4'd0, 1'b1, 5'b00001, 1'b0, 1'b0},
        {1'b0, 3'd0, 4'd0, 1'b1, 5'b00001, 1'b0, 1'b0},
        {1'b0, 3'd0, 4'd0, 1'b0, 5'b00000, 1'b1, 1'b0},
        {1'b0, 3'd0, 4'd0, 1'b1, 5'b00010, 1'b1, 1'b0},
        {1'b0, 3'd0, 4'd0, 1'b1, 5'b01000, 1'b1, 1'b0},
        {1'b0, 3'd0, 4'd0, 1'b1, 5'b00100, 1'b1, 1'b0},
        {1'b0, 3'd0, 4'd0, 1'b1, 5'b00000, 1'b1, 1'b0},
        {1'b0, 3'd0, 4'd0, 1'b0, 5'b00000, 1'b1, 1'b1},
        {1'b1, 3'd1, 4'd0, 1'b0, 5'b00000, 1'b1, 1'b1},
        {1'b0, 3'd0, 4'd0, 1'b1, 5'b00010, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [IW-1:0] iss_client = '0;
    logic [LW-1:0] iss_len = '0;
    logic          iss_ready;
    logic          ret_valid = 1'b0;
    logic [DW-1:0] ret_data = '0;
    logic [DW-1:0] bc_data;
    logic [NC-1:0] bc_valid;
    logic          err_orphan;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    rtr_top #(
        .NUM_CLIENTS (NC),
        .DATA_W      (DW),
        .LEN_W       (LW),
        .DEPTH       (4)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_valid  (iss_valid),
        .iss_client (iss_client),
        .iss_len    (iss_len),
        .iss_ready  (iss_ready),
        .ret_valid  (ret_valid),
        .ret_data   (ret_data),
        .bc_data    (bc_data),
        .bc_valid   (bc_valid),
        .err_orphan (err_orphan)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R8 ready in reset", 32'(iss_ready), 32'd1);
        check("R8 err in reset", 32'(err_orphan), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            iss_valid  = VEC[i][15];
            iss_client = VEC[i][14:12];
            iss_len    = VEC[i][11:8];
            ret_valid  = VEC[i][7];
            ret_data   = 32'hA5C0_0000 + 32'(i);
            #1;
            check($sformatf("R3 R4 R5 valid row %0d", i), 32'(bc_valid), 32'(VEC[i][6:2]));
            check($sformatf("R1 R6 ready row %0d", i), 32'(iss_ready), 32'(VEC[i][1]));
            check($sformatf("R7 err row %0d", i), 32'(err_orphan), 32'(VEC[i][0]));
            check($sformatf("R2 data row %0d", i), bc_data, 32'hA5C0_0000 + 32'(i));
        end

        // directed: reset discards a held tag and clears the flag
        @(negedge clk);
        iss_valid = 1'b1; iss_client = 3'd3; iss_len = 4'd0; ret_valid = 1'b0;
        @(negedge clk);
        iss_valid = 1'b0;
        rst_n = 1'b0;
        ret_valid = 1'b1;
        #1;
        check("R8 err cleared by reset", 32'(err_orphan), 32'd0);
        check("R8 no strobe in reset", 32'(bc_valid), 32'd0);
        check("R8 ready in reset", 32'(iss_ready), 32'd1);
        @(negedge clk);
        ret_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        ret_valid = 1'b1;
        ret_data = 32'h0000_BEEF;
        #1;
        check("R8 tag dropped by reset", 32'(bc_valid), 32'd0);
        check("R2 data after reset", bc_data, 32'h0000_BEEF);
        @(negedge clk);
        ret_valid = 1'b0;
        #1;
        check("R7 orphan after reset", 32'(err_orphan), 32'd1);

        // directed: client 0 burst of two beats after reset
        @(negedge clk);
        iss_valid = 1'b1; iss_client = 3'd0; iss_len = 4'd1;
        @(negedge clk);
        iss_valid = 1'b0; ret_valid = 1'b1;
        #1;
        check("R4 beat one", 32'(bc_valid), 32'b00001);
        @(negedge clk);
        #1;
        check("R4 beat two", 32'(bc_valid), 32'b00001);
        @(negedge clk);
        ret_valid = 1'b0;
        #1;
        check("R3 idle after burst", 32'(bc_valid), 32'd0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

endmodule